// File: doc/BRIEF.md
# Lockable GPIO Port Controller

This block is one general-purpose I/O port with one bit per pin in each of its configuration registers. Software sets each pin's direction, output level, drive style (push-pull or open-drain) and internal pull through a small register bus. The block turns those settings into per-pin pad controls: drive value, drive enable, pull-up and pull-down. It samples the pad levels through a two-flop synchroniser, and the sampled value can be read back at any time.

Each pin has a sticky lock bit. Once a pin's lock bit is set, that pin's direction, output data, drive style, pull bits and lock bit cannot be changed until reset. Writes apply bit by bit, so the unlocked pins in the same byte still update. The register bus is single cycle: a write takes effect at the clock edge where `bus_we` is high, and read data is combinational from `bus_addr`.

Register select (`bus_addr`): 0 direction, 1 output data, 2 input data (read-only), 3 drive style, 4 pull enable, 5 pull direction, 6 lock. Address 7 is unmapped.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After a synchronous reset every pin is an input with no pull, push-pull style, output data 0 and unlocked. All registers at addresses 0, 1, 3, 4, 5 and 6 read 0, and pad_oe, pad_pu and pad_pd are all 0.
- R2: A direction bit of 1 (address 0) makes the pin an output. In push-pull style (style bit 0 at address 3), pad_oe is 1 and pad_out equals the pin's output data bit (address 1). A direction bit of 0 gives pad_oe 0.
- R3: In open-drain style (style bit 1), pad_out is always 0. An output pin's pad_oe is 1 only while its output data bit is 0.
- R4: With pull enable (address 4) at 1, a pull-direction bit (address 5) of 0 raises pad_pu and a bit of 1 raises pad_pd. With pull enable at 0, both are 0. pad_pu and pad_pd are never 1 together.
- R5: The input-data register (address 2) returns pad_in as sampled two clock edges earlier. This holds whatever the pin's direction.
- R6: A pin whose lock bit (address 6) is 1 keeps its direction, output data, style, pull-enable and pull-direction bits when any of those registers is written.
- R7: Writing 0 to a lock bit has no effect. Only reset clears a lock bit, and writing 1 sets it.
- R8: A write to any configuration register updates the bits of the unlocked pins, even when other pins in the same byte are locked.
- R9: A write to address 2 changes nothing, and a read of address 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register select |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | NPINS | Write data, one bit per pin |
| bus_rdata | output | NPINS | Combinational read data for bus_addr |
| pad_in | input | NPINS | Pad input levels |
| pad_out | output | NPINS | Pad drive value |
| pad_oe | output | NPINS | Pad drive enable |
| pad_pu | output | NPINS | Pad pull-up enable |
| pad_pd | output | NPINS | Pad pull-down enable |

## Verification
The assertions assume that reset is held for at least one edge at the start. The synchroniser property also assumes that pad_in is a defined value on every edge, even though in silicon it is asynchronous. The bench drives pad_in only on falling edges and always with a known value, so sampling never meets a change at the edge. The bench changes bus inputs only on falling edges as well, and it keeps bus_addr inside the three-bit range so that the unmapped select is reached deliberately.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RS_DIR   = 3'd0,
        RS_DOUT  = 3'd1,
        RS_DIN   = 3'd2,
        RS_STYLE = 3'd3,
        RS_PEN   = 3'd4,
        RS_PDN   = 3'd5,
        RS_LOCK  = 3'd6,
        RS_NONE  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic dir;
        logic dout;
        logic od;
        logic pen;
        logic pdn;
    } pin_cfg_t;

    typedef struct packed {
        logic drv;
        logic oe;
        logic pu;
        logic pd;
    } pad_ctl_t;

    function automatic pad_ctl_t pad_from_cfg(pin_cfg_t c);
        pad_ctl_t p;
        p.drv = c.dout & ~c.od;
        p.oe  = c.dir & (~c.od | ~c.dout);
        p.pu  = c.pen & ~c.pdn;
        p.pd  = c.pen & c.pdn;
        return p;
    endfunction

endpackage

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_sel_e         wr_sel,
    input  logic [NPINS-1:0] wr_data,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] dout_q,
    output logic [NPINS-1:0] od_q,
    output logic [NPINS-1:0] pen_q,
    output logic [NPINS-1:0] pdn_q,
    output logic [NPINS-1:0] lock_q
);

    logic [NPINS-1:0] open_m;
    logic [NPINS-1:0] merged;

    assign open_m = ~lock_q;
    assign merged = (wr_data & open_m);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            dout_q <= '0;
            od_q   <= '0;
            pen_q  <= '0;
            pdn_q  <= '0;
            lock_q <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                RS_DIR:   dir_q  <= (dir_q  & lock_q) | merged;
                RS_DOUT:  dout_q <= (dout_q & lock_q) | merged;
                RS_STYLE: od_q   <= (od_q   & lock_q) | merged;
                RS_PEN:   pen_q  <= (pen_q  & lock_q) | merged;
                RS_PDN:   pdn_q  <= (pdn_q  & lock_q) | merged;
                RS_LOCK:  lock_q <= lock_q | wr_data;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NPINS  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [NPINS-1:0] async_in,
    output logic [NPINS-1:0] sync_out
);

    logic [NPINS-1:0] chain [STAGES];

    always_ff @(posedge clk) chain[0] <= async_in;

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) chain[s] <= chain[s-1];
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] dout_q,
    input  logic [NPINS-1:0] od_q,
    input  logic [NPINS-1:0] pen_q,
    input  logic [NPINS-1:0] pdn_q,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_pu,
    output logic [NPINS-1:0] pad_pd
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_cfg_t cfg;
        pad_ctl_t ctl;
        always_comb begin
            cfg.dir  = dir_q[i];
            cfg.dout = dout_q[i];
            cfg.od   = od_q[i];
            cfg.pen  = pen_q[i];
            cfg.pdn  = pdn_q[i];
            ctl      = pad_from_cfg(cfg);
        end
        assign pad_out[i] = ctl.drv;
        assign pad_oe[i]  = ctl.oe;
        assign pad_pu[i]  = ctl.pu;
        assign pad_pd[i]  = ctl.pd;
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_pu,
    output logic [NPINS-1:0]  pad_pd
);

    reg_sel_e         sel;
    logic [NPINS-1:0] dir_q, dout_q, od_q, pen_q, pdn_q, lock_q, din_q;

    assign sel = reg_sel_e'(bus_addr);

    gpio_cfg_bank #(.NPINS(NPINS)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(bus_we), .wr_sel(sel), .wr_data(bus_wdata),
        .dir_q(dir_q), .dout_q(dout_q), .od_q(od_q), .pen_q(pen_q),
        .pdn_q(pdn_q), .lock_q(lock_q)
    );

    gpio_in_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .async_in(pad_in), .sync_out(din_q)
    );

    gpio_pad_drive #(.NPINS(NPINS)) u_drive (
        .dir_q(dir_q), .dout_q(dout_q), .od_q(od_q), .pen_q(pen_q), .pdn_q(pdn_q),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
    );

    always_comb begin
        unique case (sel)
            RS_DIR:   bus_rdata = dir_q;
            RS_DOUT:  bus_rdata = dout_q;
            RS_DIN:   bus_rdata = din_q;
            RS_STYLE: bus_rdata = od_q;
            RS_PEN:   bus_rdata = pen_q;
            RS_PDN:   bus_rdata = pdn_q;
            RS_LOCK:  bus_rdata = lock_q;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [NPINS-1:0] pad_in,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] pad_pu,
    input logic [NPINS-1:0] pad_pd,
    input logic [NPINS-1:0] dir_q,
    input logic [NPINS-1:0] dout_q,
    input logic [NPINS-1:0] od_q,
    input logic [NPINS-1:0] lock_q,
    input logic [NPINS-1:0] din_q
);

    logic [1:0] cyc;
    always_ff @(posedge clk) begin
        if (rst) cyc <= 2'd0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    // R4: pull-up and pull-down never requested together
    a_r4_pull_exclusive: assert property (@(posedge clk) disable iff (rst)
        (pad_pu & pad_pd) == '0);

    // R3: open-drain pins never drive high
    a_r3_od_no_high: assert property (@(posedge clk) disable iff (rst)
        (od_q & pad_out) == '0);

    // R3: open-drain pins release the pad while data is 1
    a_r3_od_release: assert property (@(posedge clk) disable iff (rst)
        (od_q & dout_q & pad_oe) == '0);

    // R2: input pins never enable the driver
    a_r2_input_no_drive: assert property (@(posedge clk) disable iff (rst)
        (~dir_q & pad_oe) == '0);

    // R7: lock bits never fall outside reset
    a_r7_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~lock_q & $past(lock_q)) == '0));

    // R6: locked pins keep direction and output data
    a_r6_locked_hold: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((((dir_q ^ $past(dir_q)) | (dout_q ^ $past(dout_q))) & $past(lock_q)) == '0));

    if (SYNC_STAGES == 2) begin : g_sync2
        // R5: input register trails the pad by two edges
        a_r5_sync_delay: assert property (@(posedge clk) disable iff (rst)
            (cyc >= 2'd2) |-> (din_q == $past(pad_in, 2)));
    end

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk(clk), .rst(rst), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .dir_q(dir_q), .dout_q(dout_q),
    .od_q(od_q), .lock_q(lock_q), .din_q(din_q)
);

// File: tb/gpio_port_ctrl_bench.sv
module gpio_port_ctrl_bench;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out, pad_oe, pad_pu, pad_pd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_port_ctrl u_gpio_port_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
    );

    task automatic check(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic wr(logic [2:0] a, logic [N-1:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd_check(string req, logic [2:0] a, logic [N-1:0] exp);
        bus_addr = a; #1;
        check(req, $sformatf("read addr %0d", a), bus_rdata, exp);
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        rd_check("R1", 3'd0, 8'h00); rd_check("R1", 3'd1, 8'h00);
        rd_check("R1", 3'd3, 8'h00); rd_check("R1", 3'd4, 8'h00);
        rd_check("R1", 3'd5, 8'h00); rd_check("R1", 3'd6, 8'h00);
        check("R1", "pad_oe", pad_oe, 8'h00);
        check("R1", "pad_pu", pad_pu, 8'h00);
        check("R1", "pad_pd", pad_pd, 8'h00);
    endtask

    task automatic t_push_pull();
        wr(3'd1, 8'hA5);
        wr(3'd0, 8'h0F);
        #1;
        check("R2", "oe partial dir", pad_oe, 8'h0F);
        wr(3'd0, 8'hFF);
        #1;
        check("R2", "oe all out", pad_oe, 8'hFF);
        check("R2", "pad_out push-pull", pad_out, 8'hA5);
    endtask

    task automatic t_open_drain();
        wr(3'd3, 8'hF0);
        #1;
        check("R3", "pad_out open-drain", pad_out, 8'h05);
        check("R3", "pad_oe open-drain", pad_oe, 8'h5F);
        wr(3'd3, 8'h00);
    endtask

    task automatic t_pull();
        wr(3'd4, 8'h3C);
        wr(3'd5, 8'h30);
        #1;
        check("R4", "pad_pu", pad_pu, 8'h0C);
        check("R4", "pad_pd", pad_pd, 8'h30);
        wr(3'd4, 8'h00);
        #1;
        check("R4", "pu off", pad_pu, 8'h00);
        check("R4", "pd off", pad_pd, 8'h00);
    endtask

    task automatic t_input();
        @(negedge clk); pad_in = 8'h96;
        @(negedge clk);
        rd_check("R5", 3'd2, 8'h00);
        @(negedge clk);
        rd_check("R5", 3'd2, 8'h96);
        pad_in = 8'h3C;
        @(negedge clk); @(negedge clk);
        rd_check("R5", 3'd2, 8'h3C);
    endtask

    task automatic t_map();
        wr(3'd2, 8'hFF);
        rd_check("R9", 3'd2, 8'h3C);
        rd_check("R9", 3'd7, 8'h00);
        rd_check("R9", 3'd0, 8'hFF);
    endtask

    task automatic t_lock();
        do_reset();
        wr(3'd0, 8'h55); wr(3'd1, 8'h33);
        wr(3'd6, 8'h0F);
        wr(3'd0, 8'hAA);
        rd_check("R6", 3'd0, 8'hA5);
        wr(3'd1, 8'hCC);
        rd_check("R8", 3'd1, 8'hC3);
        wr(3'd3, 8'hFF);
        rd_check("R6", 3'd3, 8'hF0);
        wr(3'd4, 8'hFF);
        rd_check("R6", 3'd4, 8'hF0);
        wr(3'd5, 8'hFF);
        rd_check("R6", 3'd5, 8'hF0);
        wr(3'd6, 8'h00);
        rd_check("R7", 3'd6, 8'h0F);
        wr(3'd6, 8'h30);
        rd_check("R7", 3'd6, 8'h3F);
        wr(3'd0, 8'h00);
        rd_check("R8", 3'd0, 8'h25);
        do_reset();
        @(negedge clk);
        rd_check("R7", 3'd6, 8'h00);
    endtask

    initial begin
        t_reset();
        t_push_pull();
        t_open_drain();
        t_pull();
        t_input();
        t_map();
        t_lock();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule